// File: doc/BRIEF.md
# Multiplexed-Address DRAM Page Controller

This block turns simple read requests into the strobe and address sequence of a DRAM-style device. The device has a single address bus shared between row and column, an active-low row strobe and an active-low column strobe. Each request carries a row, a start column, a two-bit burst-length code and a mode. The controller opens the row, waits out the row-activation time, then runs one column phase per data beat and returns each beat with a one-cycle valid pulse.

When an access ends in burst or page mode, the row stays open. A later request for the same row skips activation and goes straight to its column phase. A request for a different row first closes the open row and waits a precharge interval. In basic mode every access opens its row, reads one column and closes the row again. In burst mode the controller takes only the start column from the request and counts the rest internally. In page mode each request reads one column of its own choosing from the open row.

Top module: `dram_page_ctrl`

## Requirements
- R1: After reset, `ras_no` and `cas_no` are high, `rd_valid_o` is low and `req_ready_o` is high.
- R2: `cas_no` is low only while `ras_no` is low. After each falling edge of `ras_no`, which carries the row on `dram_addr_o`, at least ROW_CYCLES cycles pass before `cas_no` first goes low.
- R3: Each column phase holds `cas_no` low for exactly COL_CYCLES cycles, and `dram_addr_o` stays stable for the whole phase. Within one request, consecutive column phases are separated by at least one cycle with `cas_no` high.
- R4: Mode 0 (basic) reads exactly one beat at the request column, whatever the burst code. It always activates the row, even when that row is already open, and leaves `ras_no` high afterwards.
- R5: Mode 1 (burst) reads 1, 2, 4 or 8 beats for burst codes 0, 1, 2 and 3. The first beat is at the start column. Each later beat is at the previous column plus one, modulo 2^COL_W.
- R6: Mode 2 (page; mode 3 behaves the same) reads one beat at the request column, whatever the burst code. If the row is already open it makes no new row activation.
- R7: A request whose row differs from the open row drives `ras_no` high for at least PRE_CYCLES cycles before the new row is activated. After basic mode closes a row, `ras_no` likewise stays high for at least PRE_CYCLES cycles before the next activation.
- R8: Each beat produces exactly one single-cycle `rd_valid_o` pulse. `rd_data_o` carries the value of `dram_data_i` sampled in the last cycle of that beat's column phase. Beats come back in issue order.
- R9: `req_ready_o` is high only when no row is open or when a row is open and idle. A request is taken on a cycle where `req_valid_i` and `req_ready_o` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller can take a request |
| req_row_i | input | ROW_W | Row of the request |
| req_col_i | input | COL_W | Start column of the request |
| req_blen_i | input | 2 | Burst code: 0→1, 1→2, 2→4, 3→8 beats |
| req_mode_i | input | 2 | 0 basic, 1 burst, 2 or 3 page |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| dram_addr_o | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_data_i | input | DATA_W | Read data from the device |
| rd_valid_o | output | 1 | One pulse per returned beat |
| rd_data_o | output | DATA_W | Returned beat |

## Verification
The bound checker watches the strobes and returned data on every cycle:
- the column strobe only ever goes low inside an open row;
- the row-activation wait and the precharge gap each meet their minimum length;
- each column phase has the right length and a stable address;
- every data pulse follows a column phase and lasts one cycle.

Some behaviour depends on which request was sent, so only the bench scenarios can show it. This covers the beat count for each burst code, the column wrap, the order of the returned data, and whether a row activation was skipped or repeated. The bench tracks these with a device model that returns data derived from the latched row and the column, and with a count of row activations.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_ACT,
    ST_COL,
    ST_GAP,
    ST_OPEN
  } dpc_state_e;

  typedef enum logic [1:0] {
    MODE_BASIC = 2'd0,
    MODE_BURST = 2'd1,
    MODE_PAGE  = 2'd2,
    MODE_PAGE2 = 2'd3
  } dpc_mode_e;
endpackage

// File: rtl/dpc_timer.sv
module dpc_timer #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= load_val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/dpc_col_gen.sv
module dpc_col_gen #(
  parameter int COL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [3:0]       nbeats_i,
  input  logic             adv_i,
  output logic [COL_W-1:0] col_o,
  output logic             last_o
);
  logic [COL_W-1:0] col_q;
  logic [3:0]       left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q  <= '0;
      left_q <= '0;
    end else if (load_i) begin
      col_q  <= start_col_i;
      left_q <= nbeats_i - 4'd1;
    end else if (adv_i && left_q != '0) begin
      col_q  <= col_q + 1'b1;   // wraps within the row
      left_q <= left_q - 4'd1;
    end
  end

  assign col_o  = col_q;
  assign last_o = (left_q == '0);
endmodule

// File: rtl/dpc_row_track.sv
module dpc_row_track #(
  parameter int ROW_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             open_i,
  input  logic             close_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [ROW_W-1:0] cmp_row_i,
  output logic             hit_o
);
  logic             vld_q;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      row_q <= '0;
    end else if (close_i) begin
      vld_q <= 1'b0;
    end else if (open_i) begin
      vld_q <= 1'b1;
      row_q <= row_i;
    end
  end

  assign hit_o = vld_q && (row_q == cmp_row_i);
endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl
  import dpc_pkg::*;
#(
  parameter int ROW_W      = 4,
  parameter int COL_W      = 4,
  parameter int DATA_W     = 8,
  parameter int ROW_CYCLES = 6,
  parameter int COL_CYCLES = 1,
  parameter int PRE_CYCLES = 2
) (
  input  logic                                         clk_i,
  input  logic                                         rst_ni,
  input  logic                                         req_valid_i,
  output logic                                         req_ready_o,
  input  logic [ROW_W-1:0]                             req_row_i,
  input  logic [COL_W-1:0]                             req_col_i,
  input  logic [1:0]                                   req_blen_i,
  input  logic [1:0]                                   req_mode_i,
  output logic                                         ras_no,
  output logic                                         cas_no,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr_o,
  input  logic [DATA_W-1:0]                            dram_data_i,
  output logic                                         rd_valid_o,
  output logic [DATA_W-1:0]                            rd_data_o
);
  localparam int AW    = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int MAXC  = (ROW_CYCLES > PRE_CYCLES) ?
                         ((ROW_CYCLES > COL_CYCLES) ? ROW_CYCLES : COL_CYCLES) :
                         ((PRE_CYCLES > COL_CYCLES) ? PRE_CYCLES : COL_CYCLES);
  localparam int TW    = $clog2(MAXC + 1);
  localparam logic [TW-1:0] ROW_LD = TW'(ROW_CYCLES - 1);
  localparam logic [TW-1:0] COL_LD = TW'(COL_CYCLES - 1);
  localparam logic [TW-1:0] PRE_LD = TW'(PRE_CYCLES - 1);

  dpc_state_e       state_q, state_d;
  dpc_mode_e        mode_q;
  logic [ROW_W-1:0] row_q;
  logic             pend_q, pend_d;
  logic             accept, hit, t_done, t_load, col_last, col_adv;
  logic [TW-1:0]    t_val;
  logic [COL_W-1:0] col_cur;
  logic [3:0]       nbeats;
  logic             row_open, row_close;

  assign req_ready_o = (state_q == ST_IDLE) || (state_q == ST_OPEN);
  assign accept      = req_valid_i && req_ready_o;
  assign nbeats      = (dpc_mode_e'(req_mode_i) == MODE_BURST) ? (4'd1 << req_blen_i) : 4'd1;

  dpc_timer #(.W(TW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (t_load),
    .load_val_i (t_val),
    .done_o     (t_done)
  );

  dpc_col_gen #(.COL_W(COL_W)) u_colgen (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (accept),
    .start_col_i (req_col_i),
    .nbeats_i    (nbeats),
    .adv_i       (col_adv),
    .col_o       (col_cur),
    .last_o      (col_last)
  );

  dpc_row_track #(.ROW_W(ROW_W)) u_rowtrk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .open_i    (row_open),
    .close_i   (row_close),
    .row_i     (row_q),
    .cmp_row_i (req_row_i),
    .hit_o     (hit)
  );

  // request capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q  <= '0;
      mode_q <= MODE_BASIC;
    end else if (accept) begin
      row_q  <= req_row_i;
      mode_q <= dpc_mode_e'(req_mode_i);
    end
  end

  always_comb begin
    state_d   = state_q;
    pend_d    = pend_q;
    t_load    = 1'b0;
    t_val     = '0;
    col_adv   = 1'b0;
    row_open  = 1'b0;
    row_close = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        state_d = ST_ACT;
        t_load  = 1'b1;
        t_val   = ROW_LD;
      end
      ST_OPEN: if (accept) begin
        if (hit && dpc_mode_e'(req_mode_i) != MODE_BASIC) begin
          state_d = ST_COL;
          t_load  = 1'b1;
          t_val   = COL_LD;
        end else begin
          state_d   = ST_PRE;
          pend_d    = 1'b1;
          row_close = 1'b1;
          t_load    = 1'b1;
          t_val     = PRE_LD;
        end
      end
      ST_PRE: if (t_done) begin
        if (pend_q) begin
          state_d = ST_ACT;
          t_load  = 1'b1;
          t_val   = ROW_LD;
        end else begin
          state_d = ST_IDLE;
        end
        pend_d = 1'b0;
      end
      ST_ACT: if (t_done) begin
        state_d  = ST_COL;
        row_open = 1'b1;
        t_load   = 1'b1;
        t_val    = COL_LD;
      end
      ST_COL: if (t_done) begin
        if (!col_last) begin
          state_d = ST_GAP;
          col_adv = 1'b1;
        end else if (mode_q == MODE_BASIC) begin
          state_d   = ST_PRE;
          pend_d    = 1'b0;
          row_close = 1'b1;
          t_load    = 1'b1;
          t_val     = PRE_LD;
        end else begin
          state_d = ST_OPEN;
        end
      end
      ST_GAP: begin
        state_d = ST_COL;
        t_load  = 1'b1;
        t_val   = COL_LD;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  // read return: sample in the last cycle of each column phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= (state_q == ST_COL) && t_done;
      if ((state_q == ST_COL) && t_done) rd_data_o <= dram_data_i;
    end
  end

  assign ras_no      = (state_q == ST_IDLE) || (state_q == ST_PRE);
  assign cas_no      = (state_q != ST_COL);
  assign dram_addr_o = (state_q == ST_COL || state_q == ST_GAP || state_q == ST_OPEN) ?
                       AW'(col_cur) : AW'(row_q);
endmodule

// File: rtl/dpc_checker.sv
module dpc_checker #(
  parameter int AW         = 4,
  parameter int ROW_CYCLES = 6,
  parameter int COL_CYCLES = 1,
  parameter int PRE_CYCLES = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ras_no,
  input logic          cas_no,
  input logic [AW-1:0] dram_addr_o,
  input logic          rd_valid_o,
  input logic          req_ready_o
);
  localparam int CW = $clog2(ROW_CYCLES + PRE_CYCLES + COL_CYCLES + 2) + 1;
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] lo_cnt, hi_cnt, cas_cnt;
  logic          was_open;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cnt   <= '0;
      hi_cnt   <= '0;
      cas_cnt  <= '0;
      was_open <= 1'b0;
    end else begin
      lo_cnt  <= ras_no ? '0 : ((lo_cnt == CMAX) ? lo_cnt : lo_cnt + 1'b1);
      hi_cnt  <= !ras_no ? '0 : ((hi_cnt == CMAX) ? hi_cnt : hi_cnt + 1'b1);
      cas_cnt <= cas_no ? '0 : ((cas_cnt == CMAX) ? cas_cnt : cas_cnt + 1'b1);
      if (!ras_no) was_open <= 1'b1;
    end
  end

  p_cas_in_row_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cas_no |-> !ras_no);

  p_row_wait_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_no) |-> (lo_cnt >= CW'(ROW_CYCLES)));

  p_col_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cas_no) |-> (cas_cnt == CW'(COL_CYCLES)));

  p_addr_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cas_no && $past(!cas_no)) |-> $stable(dram_addr_o));

  p_precharge_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_no) && was_open) |-> (hi_cnt >= CW'(PRE_CYCLES)));

  p_valid_after_cas_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(!cas_no));

  p_one_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);

  p_ready_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> cas_no);
endmodule

bind dram_page_ctrl dpc_checker #(
  .AW         ((ROW_W > COL_W) ? ROW_W : COL_W),
  .ROW_CYCLES (ROW_CYCLES),
  .COL_CYCLES (COL_CYCLES),
  .PRE_CYCLES (PRE_CYCLES)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ras_no      (ras_no),
  .cas_no      (cas_no),
  .dram_addr_o (dram_addr_o),
  .rd_valid_o  (rd_valid_o),
  .req_ready_o (req_ready_o)
);

// File: tb/sim_dram_page_ctrl.sv
`timescale 1ns/1ps
module sim_dram_page_ctrl;
  localparam int ROW_W = 4, COL_W = 4, DATA_W = 8;
  localparam int PRE_CYCLES = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic [1:0] req_blen = '0, req_mode = '0;
  logic ras_n, cas_n, rd_valid;
  logic [3:0] addr;
  logic [DATA_W-1:0] dram_data, rd_data;

  int checks = 0, fails = 0, acts = 0;
  logic [DATA_W-1:0] exp_q[$];
  logic ras_q = 1'b1;
  logic [ROW_W-1:0] row_lat = '0;

  always #2.5 clk = ~clk;

  dram_page_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_row_i(req_row), .req_col_i(req_col), .req_blen_i(req_blen), .req_mode_i(req_mode),
    .ras_no(ras_n), .cas_no(cas_n), .dram_addr_o(addr), .dram_data_i(dram_data),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data)
  );

  // device model: row latched on RAS fall, data = {row, column}
  always @(posedge clk) begin
    ras_q <= ras_n;
    if (rst_n && ras_q && !ras_n) begin
      row_lat <= addr[ROW_W-1:0];
      acts    <= acts + 1;
    end
  end
  assign dram_data = cas_n ? '0 : {row_lat, addr[COL_W-1:0]};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: R8 order and one pulse per beat
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R8: extra beat got %0h expected none", rd_data);
      end else begin
        logic [DATA_W-1:0] e;
        e = exp_q.pop_front();
        if (rd_data !== e) begin
          fails++;
          $display("FAIL R8/R5: beat got %0h expected %0h", rd_data, e);
        end
      end
    end
  end

  task automatic send(input int row, input int col, input int blen, input int mode, input bit chk_busy);
    int n;
    n = (mode == 1) ? (1 << blen) : 1;
    for (int i = 0; i < n; i++) exp_q.push_back({row[ROW_W-1:0], 4'(col + i)});
    @(negedge clk);
    req_row = row[ROW_W-1:0]; req_col = col[COL_W-1:0];
    req_blen = blen[1:0]; req_mode = mode[1:0]; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (chk_busy) chk("R9 ready low while busy", int'(req_ready), 0);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (PRE_CYCLES + 4) @(negedge clk);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ras_no", int'(ras_n), 1);
    chk("R1 cas_no", int'(cas_n), 1);
    chk("R1 rd_valid", int'(rd_valid), 0);
    chk("R1 ready", int'(req_ready), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    send(3, 2, 1, 1, 1'b1); drain();           // R5 two beats
    chk("R2 first activation", acts, 1);
    chk("R9 ready with open row", int'(req_ready), 1);
    chk("R6 row held open", int'(ras_n), 0);

    send(3, 9, 3, 2, 1'b0); send(3, 0, 0, 3, 1'b0); drain();  // R6 page hits
    chk("R6 no reactivation", acts, 1);

    send(3, 14, 2, 1, 1'b0); drain();          // R5 wrap 14,15,0,1
    chk("R5 burst hit no activation", acts, 1);

    send(5, 0, 3, 1, 1'b0); drain();           // R7 row miss, 8 beats
    chk("R7 miss reactivates", acts, 2);

    send(5, 7, 3, 2, 1'b0); drain();           // R6 blen ignored
    chk("R6 page hit", acts, 2);

    send(5, 4, 2, 0, 1'b0); drain();           // R4 basic on open row
    chk("R4 basic activates", acts, 3);
    chk("R4 row closed", int'(ras_n), 1);

    send(6, 1, 3, 0, 1'b0); drain();
    chk("R4 basic second", acts, 4);
    chk("R4 row closed again", int'(ras_n), 1);

    send(6, 15, 0, 1, 1'b1); drain();          // R5 single beat from idle
    chk("R5 activation from idle", acts, 5);
    chk("R8 queue empty", exp_q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule